// File: doc/BRIEF.md
# Converter Serial Output Port with Cascade Input

This block is the digital read-out side of a sampling converter. A rising edge on the convert strobe starts a conversion. At that edge the port also picks its operating mode from the level of the serial input. A fixed-latency timer stands in for the analog conversion. When the timer expires, the supplied sample word is loaded into an output shift register. The host then clocks that register out on the serial data line, one bit per serial clock, most significant bit first.

There are two modes. In select mode the output is driven only while the port is selected. In cascade mode the output is always driven, and the serial input feeds the tail of the shift register, so several converters can share one data line and read out as one long shift register. In either mode a start bit can be placed in front of the data. The host can use that bit as an interrupt instead of timing out the conversion.

All pins are sampled by the system clock. The host is expected to hold each pin level for at least two system clocks.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo` is 0, `sdo_oe` is 1, and the port is in cascade mode with no start bit pending.
- R2: At a rising edge of `cnv`, the port latches the level `sdi` had one system clock earlier. A 1 selects select mode and a 0 selects cascade mode. The mode holds until the next accepted strobe.
- R3: When `sdi` and `cnv` rise in the same clock, the port enters cascade mode.
- R4: The sample word loads exactly `CONV_CYCLES` system clocks after the clock that sees the `cnv` rising edge. While the conversion runs, `sdo` is 0, and both serial clock edges and further `cnv` rising edges are ignored.
- R5: After the load, `sdo` shows bit `DATA_W-1` of the word. Each falling edge of `sck` advances `sdo` to the next lower bit, and `sdo` holds between falling edges.
- R6: In cascade mode, each shift moves the `sdi` level present at that `sck` falling edge into the register tail. In select mode, zeros fill the tail whatever `sdi` does.
- R7: In select mode, a start bit is armed if `cnv` or `sdi` is 0 in the clock where the load happens.
- R8: In cascade mode, a start bit is armed if `sck` was 1 in the clock before the `cnv` rising edge.
- R9: An armed start bit sets `sdo` to 1 from the load onward. The first `sck` falling edge after the load clears it without shifting, and the data bits then follow as in R5.
- R10: In select mode, `sdo_oe` is 0 exactly when both `cnv` and `sdi` are 1. In cascade mode, `sdo_oe` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cnv | input | 1 | Convert strobe; rising edge starts a conversion; also a select line in select mode |
| sdi | input | 1 | Mode strap at strobe, select line in select mode, cascade input in cascade mode |
| sck | input | 1 | Serial clock; data advances on its falling edge |
| sample | input | DATA_W | Conversion result loaded when the timer expires |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable; 0 models a high-impedance line |

## Verification
The assertions assume that the serial clock, the strobe and the serial input come from a host that is synchronous to the system clock and holds every level for at least two system clocks, so that each edge is seen exactly once. The bench drives every pin on the falling system clock and spaces all pin changes at least two clocks apart. It also sets `sdi` at least one clock before each strobe, except in the tied-pin case, where both pins rise in the same clock on purpose. Select-mode runs keep one of `cnv` or `sdi` low while they read, which holds the port selected.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sdi,
  input  logic              sck,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CONV_CYCLES - 1);

  logic              cnv_q, sdi_q, sck_q;
  logic              cs_mode, chain_busy, converting, start_pend;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;

  wire cnv_rise = cnv & ~cnv_q;
  wire sck_fall = sck_q & ~sck;
  wire tail_in  = ~cs_mode & sdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q      <= 1'b0;
      sdi_q      <= 1'b0;
      sck_q      <= 1'b0;
      cs_mode    <= 1'b0;
      chain_busy <= 1'b0;
      converting <= 1'b0;
      start_pend <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
    end else begin
      cnv_q <= cnv;
      sdi_q <= sdi;
      sck_q <= sck;
      if (converting) begin
        if (cnt == '0) begin
          converting <= 1'b0;
          shreg      <= sample;
          start_pend <= cs_mode ? (~cnv | ~sdi) : chain_busy;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (cnv_rise) begin
        cs_mode    <= sdi_q;
        chain_busy <= ~sdi_q & sck_q;
        converting <= 1'b1;
        cnt        <= CNT_TOP;
        shreg      <= '0;
        start_pend <= 1'b0;
      end else if (sck_fall) begin
        if (start_pend) start_pend <= 1'b0;
        else            shreg      <= {shreg[DATA_W-2:0], tail_in};
      end
    end
  end

  assign sdo    = start_pend | shreg[DATA_W-1];
  assign sdo_oe = ~cs_mode | ~cnv | ~sdi;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int CONV_CYCLES = 20,
  parameter int CNT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv,
  input logic             sdi,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             cs_mode,
  input logic             converting,
  input logic             start_pend,
  input logic [CNT_W-1:0] cnt
);
  assert_quiet_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    converting |-> !sdo);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < CONV_CYCLES);

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && $past(converting)) |-> $stable(cs_mode));

  assert_start_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pend) |-> $fell(converting));

  assert_chain_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_mode |-> sdo_oe);

  assert_deselect_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_mode && cnv && sdi) |-> !sdo_oe);
endmodule

bind adc_serial_port adc_serial_port_chk #(
  .CONV_CYCLES(CONV_CYCLES),
  .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
  .cs_mode(cs_mode), .converting(converting), .start_pend(start_pend), .cnt(cnt)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
  localparam int W     = 18;
  localparam int CONV  = 20;
  localparam int NBITS = 36;

  logic clk = 0, rst_n = 0, cnv = 0, sdi = 0, sck = 0;
  logic [W-1:0] sample = '0;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  adc_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic pat(input int j, input logic [W-1:0] down);
    return (j >= 1 && j <= W) ? down[W-j] : 1'b0;
  endfunction

  // modes: 0 cascade, 1 cascade+start, 2 select 3-wire, 3 select 3-wire+start,
  //        4 select 4-wire+start, 5 tied pins
  function automatic logic [NBITS-1:0] expect_frame(input int mode, input logic [W-1:0] d,
                                                     input logic [W-1:0] down);
    logic [NBITS-1:0] f;
    int busy = (mode == 1 || mode == 3 || mode == 4) ? 1 : 0;
    for (int k = 0; k < NBITS; k++) begin
      logic b;
      if (busy == 1 && k == 0)  b = 1'b1;
      else if (k < W + busy)    b = d[W-1-(k-busy)];
      else if (mode == 5)       b = 1'b1;
      else if (mode <= 1)       b = pat(k - 17, down);
      else                      b = 1'b0;
      f[NBITS-1-k] = b;
    end
    return f;
  endfunction

  task automatic read_frame(input int mode, input logic [W-1:0] down, output logic [NBITS-1:0] got);
    for (int k = 0; k < NBITS; k++) begin
      sck = 1;
      if (mode <= 1) sdi = pat(k + 1, down);
      tick(2);
      got[NBITS-1-k] = sdo;
      sck = 0;
      tick(2);
    end
  endtask

  task automatic run_conv(input int mode, input logic [W-1:0] d, input logic [W-1:0] down);
    logic [NBITS-1:0] got;
    string tag;
    sample = d;
    case (mode)
      0: begin
        tag = "R2 R4 R5 R6";
        sdi = 0; sck = 0; tick(2); cnv = 1; tick(3);
        sdi = 1; cnv = 0; tick(2); cnv = 1; tick(2); sdi = 0;  // ignored re-strobe, R4
        tick(CONV);
      end
      1: begin
        tag = "R8 R9 R6";
        sdi = 0; sck = 1; tick(2); cnv = 1; tick(2); sck = 0;  // ignored fall, R4
        tick(CONV + 2);
      end
      2: begin
        tag = "R2 R5 R6";
        sdi = 1; sck = 0; tick(2); cnv = 1; tick(CONV + 2);
        check("R10 deselected", 64'(sdo_oe), 64'd0);
        cnv = 0; tick(1);
        check("R10 selected", 64'(sdo_oe), 64'd1);
      end
      3: begin
        tag = "R7 R9";
        sdi = 1; sck = 0; tick(2); cnv = 1; tick(2); cnv = 0; tick(CONV - 2);
        check("R4 before load", 64'(sdo), 64'd0);
        tick(1);
        check("R4 R9 start bit at load", 64'(sdo), 64'd1);
        tick(1);
      end
      4: begin
        tag = "R7 R9";
        sdi = 1; sck = 0; tick(2); cnv = 1; tick(2); sdi = 0; tick(CONV + 2);
        check("R10 selected 4-wire", 64'(sdo_oe), 64'd1);
      end
      default: begin
        tag = "R3";
        sdi = 0; sck = 0; tick(2); cnv = 1; sdi = 1; tick(CONV + 2);
      end
    endcase
    read_frame(mode, down, got);
    check(tag, 64'(got), 64'(expect_frame(mode, d, down)));
    cnv = 0; sdi = 0; sck = 0; tick(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    check("R1 sdo", 64'(sdo), 64'd0);
    check("R1 sdo_oe", 64'(sdo_oe), 64'd1);
    for (int mode = 0; mode < 6; mode++) begin
      for (int b = 0; b < W + 2; b++) begin
        logic [W-1:0] d, down;
        if (b < W)       d = W'(1) << b;
        else if (b == W) d = '1;
        else             d = W'(18'h2AAAA);
        down = ~d ^ W'(b * 37);
        run_conv(mode, d, down);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule